// File: doc/BRIEF.md
# Pseudo-Random Noise Channel

This block produces a 4-bit noise sample from a 15-bit linear feedback shift register. A down-counter times out at a rate drawn from one of two 16-entry period tables. The caller picks the table with a timing-region input and picks the entry with a 4-bit period index. Each time the counter times out, the register shifts once, the sample is recomputed and a one-cycle strobe is raised.

Two feedback arrangements are available. In long mode, bits 0 and 1 are combined. In short mode, bits 0 and 6 are combined, which gives a far shorter repeating pattern. The loudness value arrives directly on an input. Envelope shaping and note-length control are left to neighbouring logic.

Top module: `noise_channel`

## Requirements
- R1: While `rstN` is low, `sample` is 0 and `stepped` is 0 and the register holds 1. The first timeout occurs at the first rising edge after `rstN` goes high.
- R2: After a timeout, the next timeout comes exactly N cycles later. N is the table entry selected by `periodIdx` and `regionSel` in the cycle of the earlier timeout. Inputs that change between timeouts do not alter the running count.
- R3: With `regionSel`=0, entries 0 to 15 are 4, 8, 16, 32, 64, 96, 128, 160, 202, 254, 380, 508, 762, 1016, 2034 and 4068 cycles.
- R4: With `regionSel`=1, a separate parameter table is used. Its defaults are 4, 8, 14, 30, 60, 88, 118, 148, 188, 236, 354, 472, 708, 944, 1890 and 3778.
- R5: With `shortMode`=0, each timeout shifts the register right by one. The value (bit 0 XOR bit 1) enters bit 14, and the result keeps only 15 bits.
- R6: With `shortMode`=1, the bit entering bit 14 is bit 0 XOR bit 6.
- R7: At each timeout, `sample` becomes 0 if bit 0 of the shifted register is 1, and otherwise becomes `volume`. Between timeouts, `sample` holds, whatever `volume` does.
- R8: `stepped` is high for exactly the one cycle that follows each timeout edge, and is low at all other times.
- R9: The register never holds the all-zero value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| periodIdx | input | 4 | Period table entry |
| regionSel | input | 1 | 0 = primary table, 1 = alternate table |
| shortMode | input | 1 | 1 = short feedback tap (bit 6) |
| volume | input | 4 | Amplitude applied when the sample is on |
| sample | output | 4 | Current noise sample |
| stepped | output | 1 | One-cycle pulse after each timeout |

## Verification
On every cycle, the embedded assertions check the following:
- the counter never reaches zero and steps down by one between timeouts;
- a timeout is always followed by the strobe;
- the register shifts the right way in long mode;
- the register is never all-zero;
- the sample holds between timeouts.

The exact table values for both regions, and the point at which index changes take effect, show up only in the bench's measured intervals. The bench also follows the bit-for-bit sample sequences under random mixes of mode, volume and period, which only its scenarios can show.

// File: rtl/noise_pkg.sv
package noise_pkg;
  localparam int IDX_W  = 4;
  localparam int CNT_W  = 12;
  localparam int LFSR_W = 15;
  localparam int VOL_W  = 4;
  localparam int TAB_N  = 1 << IDX_W;

  typedef logic [CNT_W-1:0] period_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic expire;
    logic useShort;
  } noiseStrobe_t;

  localparam period_t PRIMARY_PERIODS [TAB_N] = '{
    12'd4, 12'd8, 12'd16, 12'd32, 12'd64, 12'd96, 12'd128, 12'd160,
    12'd202, 12'd254, 12'd380, 12'd508, 12'd762, 12'd1016, 12'd2034, 12'd4068
  };

  localparam period_t ALTERNATE_PERIODS [TAB_N] = '{
    12'd4, 12'd8, 12'd14, 12'd30, 12'd60, 12'd88, 12'd118, 12'd148,
    12'd188, 12'd236, 12'd354, 12'd472, 12'd708, 12'd944, 12'd1890, 12'd3778
  };
endpackage

// File: rtl/noise_ctrl.sv
module noise_ctrl
  import noise_pkg::*;
#(
  parameter int IDX_BITS = IDX_W,
  parameter int CNT_BITS = CNT_W,
  parameter period_t PRI_TABLE [TAB_N] = PRIMARY_PERIODS,
  parameter period_t ALT_TABLE [TAB_N] = ALTERNATE_PERIODS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [IDX_BITS-1:0] periodIdx,
  input  logic                regionSel,
  input  logic                shortMode,
  output noiseStrobe_t        strobe,
  output logic                stepped
);
  logic [CNT_BITS-1:0] cnt;
  logic [CNT_BITS-1:0] reloadVal;
  logic                expire;

  assign expire    = (cnt == CNT_BITS'(1));
  assign reloadVal = regionSel ? ALT_TABLE[periodIdx] : PRI_TABLE[periodIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= CNT_BITS'(1);
      stepped <= 1'b0;
    end else begin
      stepped <= expire;
      cnt     <= expire ? reloadVal : cnt - CNT_BITS'(1);
    end
  end

  always_comb begin
    strobe.expire   = expire;
    strobe.useShort = shortMode;
  end

  // R2: counter never idles at zero
  assert_cnt_nonzero_R2: assert property (@(posedge clk) disable iff (!rstN)
    cnt != '0);
  // R2: between timeouts the count steps down by one
  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    !expire |=> cnt == $past(cnt) - CNT_BITS'(1));
  // R8: every timeout raises the strobe on the next cycle
  assert_strobe_follows_R8: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> stepped);
  // R8: strobe only after a timeout
  assert_strobe_only_R8: assert property (@(posedge clk) disable iff (!rstN)
    !expire |=> !stepped);
endmodule

// File: rtl/noise_dp.sv
module noise_dp
  import noise_pkg::*;
#(
  parameter int SR_BITS   = LFSR_W,
  parameter int VOL_BITS  = VOL_W,
  parameter int LONG_TAP  = 1,
  parameter int SHORT_TAP = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  noiseStrobe_t        strobe,
  input  logic [VOL_BITS-1:0] volume,
  output logic [VOL_BITS-1:0] sample
);
  logic [SR_BITS-1:0] lfsr;
  logic [SR_BITS-1:0] nextLfsr;
  logic               feedback;

  assign feedback = lfsr[0] ^ (strobe.useShort ? lfsr[SHORT_TAP] : lfsr[LONG_TAP]);

  for (genvar i = 0; i < SR_BITS - 1; i++) begin : gShift
    assign nextLfsr[i] = lfsr[i+1];
  end
  assign nextLfsr[SR_BITS-1] = feedback;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsr   <= SR_BITS'(1);
      sample <= '0;
    end else if (strobe.expire) begin
      lfsr   <= nextLfsr;
      sample <= nextLfsr[0] ? '0 : volume;
    end
  end

  // R9: register never reaches the all-zero state
  assert_lfsr_nonzero_R9: assert property (@(posedge clk) disable iff (!rstN)
    lfsr != '0);
  // R7: sample holds between timeouts
  assert_sample_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.expire |=> $stable(sample));
  // R5: long mode moves every bit one place toward bit 0
  assert_long_shift_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.expire && !strobe.useShort) |=>
      (lfsr[SR_BITS-2:0] == $past(lfsr[SR_BITS-1:1])) &&
      (lfsr[SR_BITS-1] == ($past(lfsr[0]) ^ $past(lfsr[LONG_TAP]))));
  // R6: short mode feeds bit 0 XOR bit 6
  assert_short_fb_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.expire && strobe.useShort) |=>
      lfsr[SR_BITS-1] == ($past(lfsr[0]) ^ $past(lfsr[SHORT_TAP])));
endmodule

// File: rtl/noise_channel.sv
module noise_channel
  import noise_pkg::*;
#(
  parameter period_t PRI_TABLE [TAB_N] = PRIMARY_PERIODS,
  parameter period_t ALT_TABLE [TAB_N] = ALTERNATE_PERIODS
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] periodIdx,
  input  logic             regionSel,
  input  logic             shortMode,
  input  logic [VOL_W-1:0] volume,
  output logic [VOL_W-1:0] sample,
  output logic             stepped
);
  noiseStrobe_t strobe;

  noise_ctrl #(
    .IDX_BITS(IDX_W), .CNT_BITS(CNT_W),
    .PRI_TABLE(PRI_TABLE), .ALT_TABLE(ALT_TABLE)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .periodIdx(periodIdx), .regionSel(regionSel),
    .shortMode(shortMode), .strobe(strobe), .stepped(stepped)
  );

  noise_dp #(.SR_BITS(LFSR_W), .VOL_BITS(VOL_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .volume(volume), .sample(sample)
  );
endmodule

// File: tb/tb_noise_channel.sv
module tb_noise_channel;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] periodIdx = '0;
  logic       regionSel = 1'b0;
  logic       shortMode = 1'b0;
  logic [3:0] volume = 4'd0;
  logic [3:0] sample;
  logic       stepped;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // model state
  int        mCnt;
  bit [14:0] mLfsr;
  bit [3:0]  mSample;
  bit        mStepped;
  bit        mValid = 0;

  always #4 clk = ~clk;  // 125 MHz

  noise_channel dut (
    .clk(clk), .rstN(rstN), .periodIdx(periodIdx), .regionSel(regionSel),
    .shortMode(shortMode), .volume(volume), .sample(sample), .stepped(stepped)
  );

  function automatic int periodOf(bit region, int idx);
    int pri [16] = '{4, 8, 16, 32, 64, 96, 128, 160, 202, 254, 380, 508, 762, 1016, 2034, 4068};
    int alt [16] = '{4, 8, 14, 30, 60, 88, 118, 148, 188, 236, 354, 472, 708, 944, 1890, 3778};
    return region ? alt[idx] : pri[idx];
  endfunction

  function automatic bit [14:0] shiftOnce(bit [14:0] s, bit shortM);
    bit fb;
    fb = s[0] ^ (shortM ? s[6] : s[1]);
    return {fb, s[14:1]};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model, advanced on the same edges as the design
  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 1; mLfsr = 15'd1; mSample = 0; mStepped = 0; mValid = 1;
    end else if (mValid) begin
      mStepped = (mCnt == 1);
      if (mCnt == 1) begin
        mLfsr   = shiftOnce(mLfsr, shortMode);
        mSample = mLfsr[0] ? 4'd0 : volume;
        mCnt    = periodOf(regionSel, periodIdx);
      end else begin
        mCnt--;
      end
    end
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN && mValid && !finished) begin
      check(stepped == mStepped, "R8 stepped", stepped, mStepped);
      check(sample == mSample, shortMode ? "R6/R7 sample" : "R5/R7 sample", sample, mSample);
    end
  end

  task automatic waitStep();
    @(negedge clk);
    while (!stepped) @(negedge clk);
  endtask

  task automatic measureGap(bit region, int idx, string req);
    int gap;
    regionSel = region; periodIdx = 4'(idx);
    waitStep(); waitStep();
    gap = 0;
    do begin @(negedge clk); gap++; end while (!stepped);
    check(gap == periodOf(region, idx), req, gap, periodOf(region, idx));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [3:0] held;
    void'($urandom(32'd4242));
    volume = 4'd9;
    repeat (3) @(negedge clk);
    // R1: reset values
    check(sample == 0, "R1 reset sample", sample, 0);
    check(stepped == 0, "R1 reset stepped", stepped, 0);
    rstN = 1'b1;
    @(negedge clk);
    // R1: first timeout right after release; 1 -> 0x4000, bit0 = 0 so sample = volume
    check(stepped == 1, "R1 first step", stepped, 1);
    check(sample == 9, "R1/R5 first sample", sample, 9);

    // R3: primary table intervals
    for (int i = 0; i < 16; i += 3) measureGap(1'b0, i, "R3 primary period");
    measureGap(1'b0, 15, "R3 primary period");
    // R4: alternate table intervals
    for (int i = 1; i < 16; i += 4) measureGap(1'b1, i, "R4 alternate period");

    // R2: index change mid-interval does not alter the running count
    regionSel = 0; periodIdx = 4'd6;
    waitStep(); waitStep();
    repeat (10) @(negedge clk);
    periodIdx = 4'd0;
    begin
      int g = 10;
      do begin @(negedge clk); g++; end while (!stepped);
      check(g == 128, "R2 mid-change", g, 128);
    end

    // R7: volume change between timeouts leaves sample unchanged
    periodIdx = 4'd5;
    waitStep();
    held = sample;
    volume = ~volume;
    repeat (5) @(negedge clk);
    check(sample == held, "R7 volume ignored", sample, held);

    // R6: short mode run
    shortMode = 1; periodIdx = 0; volume = 4'd15;
    repeat (2000) @(negedge clk);

    // random mixes, checked by the model on every cycle
    for (int s = 0; s < 80; s++) begin
      periodIdx = 4'($urandom_range(0, 9));
      regionSel = 1'($urandom);
      shortMode = 1'($urandom);
      volume    = 4'($urandom);
      repeat ($urandom_range(20, 600)) @(negedge clk);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule